// File: doc/BRIEF.md
# Tagged Multi-Channel Debug Word FIFO

This peripheral carries 32-bit words between a processor and an external debug host over sixteen logical channels. Each direction has a single shared FIFO, and every entry holds a 4-bit channel tag next to its data word. The processor writes one of sixteen transmit addresses, and the address selects the tag. It learns the tag of the oldest received word from the status register before it reads that word out.

The processor side is a simple register port: address, write strobe, read strobe and write data, with read data returned combinationally in the same cycle. A read of the receive address removes the head entry at the next clock edge. The host side has two valid/ready word streams, one leaving the transmit FIFO and one entering the receive FIFO, each with its channel tag. A level interrupt is raised from programmable fill thresholds on either FIFO.

Top module: `dcf_debug_fifo`

## Requirements
- R1: The configuration register (offset 0x08) holds the TX threshold mode in bits 19:18 and the RX threshold mode in bits 17:16, both writable and read back. Bits 15:8 read the TX depth and bits 7:0 read the RX depth. Writes to all other bits have no effect. Offset 0x00 reads zero.
- R2: A write to offset 0x20 + 8*n (n = 0..15) places the written word in the TX FIFO tagged with channel n. The host stream delivers such words in write order with the tag on host_tx_chan.
- R3: A write to a transmit address while the TX FIFO is full is dropped. The occupancy stays at the depth and the stored words are delivered unchanged.
- R4: A read of offset 0x18 returns the head RX word and pops it. The status channel field (bits 7:4) always shows the tag of the current head entry, so after a pop it shows the next one.
- R5: A read of offset 0x18 while the RX FIFO is empty returns zero and removes nothing.
- R6: The status register (offset 0x10) shows the TX occupancy in bits 31:24 and the RX occupancy in bits 23:16. Bit 3 is RX empty, bit 2 is RX full, bit 1 is TX empty and bit 0 is TX full.
- R7: The TX threshold modes are 0 off, 1 FIFO empty, 2 FIFO not full, and 3 occupancy at most one quarter of the depth.
- R8: The RX threshold modes are 0 off, 1 FIFO full, 2 FIFO not empty, and 3 occupancy at least three quarters of the depth.
- R9: irq is a level output. It is the OR of the TX and RX threshold conditions, evaluated from the current occupancies and modes. It falls as soon as neither condition holds.
- R10: host_rx_ready is low while the RX FIFO is full. A word offered then is not stored.
- R11: After reset both FIFOs are empty, both threshold modes are off, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX when at 0x18) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| host_tx_valid | output | 1 | TX head word available to host |
| host_tx_ready | input | 1 | Host accepts TX word |
| host_tx_data | output | 32 | TX head word |
| host_tx_chan | output | 4 | Channel tag of TX head word |
| host_rx_valid | input | 1 | Host offers an RX word |
| host_rx_ready | output | 1 | RX FIFO has room |
| host_rx_data | input | 32 | Offered RX word |
| host_rx_chan | input | 4 | Channel tag of offered RX word |
| irq | output | 1 | Level threshold interrupt |

## Verification
The in-line assertions check on every cycle that neither FIFO exceeds its depth, that a push into a full FIFO and a pop from an empty one leave it unchanged, and that an accepted transmit write adds exactly one entry. They also check that an empty receive read returns zero and that the interrupt follows the empty, full and disabled modes. Other behaviour needs the bench's scenarios. These cover channel tags carried in order through the shared FIFOs, the status channel field advancing after each pop, the quarter-fill thresholds at their exact boundary counts, config fields that cannot be written, and the word dropped at full being absent from the host stream.

// File: rtl/dcf_pkg.sv
// Shared constants and types for the tagged debug word FIFO.
// Assumes byte addressing with 8-byte register spacing.
package dcf_pkg;
    localparam int WORD_W = 32;
    localparam int CHAN_W = 4;
    localparam int NUM_CHAN = 16;

    localparam logic [7:0] OFS_ACCESS = 8'h00;
    localparam logic [7:0] OFS_CONFIG = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_RXDATA = 8'h18;
    localparam int TX_WORD_BASE = 4;  // 0x20 >> 3

    typedef enum logic [1:0] {
        TXT_OFF       = 2'd0,
        TXT_EMPTY     = 2'd1,
        TXT_NOTFULL   = 2'd2,
        TXT_NEAREMPTY = 2'd3
    } tx_thr_e;

    typedef enum logic [1:0] {
        RXT_OFF      = 2'd0,
        RXT_FULL     = 2'd1,
        RXT_NOTEMPTY = 2'd2,
        RXT_NEARFULL = 2'd3
    } rx_thr_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [WORD_W-1:0] data;
    } tagged_word_t;
endpackage

// File: rtl/dcf_fifo.sv
// Synchronous FIFO with occupancy count. A push when full and a pop when
// empty are ignored. Push and pop may occur in the same cycle.
// Assumes DEPTH >= 2.
module dcf_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 36,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_full_push_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(count)));
    p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/dcf_irq.sv
// Threshold interrupt: ORs the TX and RX fill conditions selected by the
// mode fields. Purely combinational from registered counts and modes.
module dcf_irq
    import dcf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TXC_W = $clog2(TX_DEPTH + 1),
    localparam int RXC_W = $clog2(RX_DEPTH + 1),
    localparam int TXQ_W = TXC_W + 3,
    localparam int RXQ_W = RXC_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tx_thr_e          tx_mode,
    input  rx_thr_e          rx_mode,
    input  logic [TXC_W-1:0] tx_cnt,
    input  logic [RXC_W-1:0] rx_cnt,
    output logic             irq
);
    logic [TXQ_W-1:0] tx_x4;
    logic [RXQ_W-1:0] rx_x4;
    logic             tx_hit, rx_hit;

    assign tx_x4 = TXQ_W'({tx_cnt, 2'b00});
    assign rx_x4 = RXQ_W'({rx_cnt, 2'b00});

    // TX condition selected by mode.
    always_comb begin
        case (tx_mode)
            TXT_EMPTY:     tx_hit = (tx_cnt == '0);
            TXT_NOTFULL:   tx_hit = (tx_cnt != TXC_W'(TX_DEPTH));
            TXT_NEAREMPTY: tx_hit = (tx_x4 <= TXQ_W'(TX_DEPTH));
            default:       tx_hit = 1'b0;
        endcase
    end

    // RX condition selected by mode.
    always_comb begin
        case (rx_mode)
            RXT_FULL:     rx_hit = (rx_cnt == RXC_W'(RX_DEPTH));
            RXT_NOTEMPTY: rx_hit = (rx_cnt != '0);
            RXT_NEARFULL: rx_hit = (rx_x4 >= RXQ_W'(3 * RX_DEPTH));
            default:      rx_hit = 1'b0;
        endcase
    end

    assign irq = tx_hit || rx_hit;

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == TXT_OFF && rx_mode == RXT_OFF) |-> !irq);
    p_tx_empty_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == TXT_EMPTY && tx_cnt == '0) |-> irq);
    p_rx_full_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == RXT_FULL && rx_cnt == RXC_W'(RX_DEPTH)) |-> irq);
endmodule

// File: rtl/dcf_debug_fifo.sv
// Top: register decode, threshold configuration, status assembly, and the
// two tagged FIFOs with their host-side valid/ready streams.
// Assumes ADDR_W >= 8 and depths of 2..127 words.
module dcf_debug_fifo
    import dcf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              host_tx_valid,
    input  logic              host_tx_ready,
    output logic [WORD_W-1:0] host_tx_data,
    output logic [CHAN_W-1:0] host_tx_chan,
    input  logic              host_rx_valid,
    output logic              host_rx_ready,
    input  logic [WORD_W-1:0] host_rx_data,
    input  logic [CHAN_W-1:0] host_rx_chan,
    output logic              irq
);
    localparam int TXC_W = $clog2(TX_DEPTH + 1);
    localparam int RXC_W = $clog2(RX_DEPTH + 1);
    localparam int ENT_W = $bits(tagged_word_t);
    localparam int IDX_W = ADDR_W - 3;

    tx_thr_e      tx_mode;
    rx_thr_e      rx_mode;
    tagged_word_t tx_in, tx_head, rx_in, rx_head;
    logic [TXC_W-1:0] tx_cnt;
    logic [RXC_W-1:0] rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [IDX_W-1:0] word_idx;
    logic sel_tx, sel_cfg, sel_rx;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic [CHAN_W-1:0] head_chan;

    // Address decode for the transmit window and single registers.
    assign word_idx = reg_addr[ADDR_W-1:3];
    assign sel_tx   = (reg_addr[2:0] == 3'b000) &&
                      (word_idx >= IDX_W'(TX_WORD_BASE)) &&
                      (word_idx <  IDX_W'(TX_WORD_BASE + NUM_CHAN));
    assign sel_cfg  = (reg_addr == ADDR_W'(OFS_CONFIG));
    assign sel_rx   = (reg_addr == ADDR_W'(OFS_RXDATA));

    assign tx_push    = reg_wr && sel_tx;
    assign tx_in.chan = CHAN_W'(word_idx - IDX_W'(TX_WORD_BASE));
    assign tx_in.data = reg_wdata;
    assign tx_pop     = host_tx_valid && host_tx_ready;

    assign rx_push    = host_rx_valid && host_rx_ready;
    assign rx_in.chan = host_rx_chan;
    assign rx_in.data = host_rx_data;
    assign rx_pop     = reg_rd && sel_rx;

    dcf_fifo #(.DEPTH(TX_DEPTH), .WIDTH(ENT_W)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_in),
        .pop(tx_pop), .head_data(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    dcf_fifo #(.DEPTH(RX_DEPTH), .WIDTH(ENT_W)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_in),
        .pop(rx_pop), .head_data(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign host_tx_valid = !tx_empty;
    assign host_tx_data  = tx_head.data;
    assign host_tx_chan  = tx_head.chan;
    assign host_rx_ready = !rx_full;
    assign head_chan     = rx_empty ? '0 : rx_head.chan;

    // Threshold mode register, written through the configuration offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mode <= TXT_OFF;
            rx_mode <= RXT_OFF;
        end else if (reg_wr && sel_cfg) begin
            tx_mode <= tx_thr_e'(reg_wdata[19:18]);
            rx_mode <= rx_thr_e'(reg_wdata[17:16]);
        end
    end

    // Read data multiplexer, combinational from the address.
    always_comb begin
        reg_rdata = '0;
        if (sel_cfg)
            reg_rdata = {12'b0, tx_mode, rx_mode, 8'(TX_DEPTH), 8'(RX_DEPTH)};
        else if (reg_addr == ADDR_W'(OFS_STATUS))
            reg_rdata = {8'(tx_cnt), 8'(rx_cnt), 8'b0, head_chan,
                         rx_empty, rx_full, tx_empty, tx_full};
        else if (sel_rx)
            reg_rdata = rx_empty ? '0 : rx_head.data;
    end

    dcf_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .tx_mode(tx_mode), .rx_mode(rx_mode),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .irq(irq)
    );

    p_rx_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_rx && rx_empty) |-> (reg_rdata == '0));
    p_tx_accept_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt) + 1'b1));
    p_rx_full_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && host_rx_valid && !rx_pop) |=> (rx_cnt == RXC_W'(RX_DEPTH)));
endmodule

// File: tb/dcf_debug_fifo_tb_top.sv
module dcf_debug_fifo_tb_top;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_tx_valid, host_tx_ready = 1'b0;
    logic [31:0] host_tx_data;
    logic [3:0]  host_tx_chan;
    logic        host_rx_valid = 1'b0, host_rx_ready;
    logic [31:0] host_rx_data = '0;
    logic [3:0]  host_rx_chan = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    logic [35:0] exp_tx[$];
    logic [35:0] exp_rx[$];

    always #2 clk = ~clk;  // 250 MHz

    dcf_debug_fifo #(.TX_DEPTH(D), .RX_DEPTH(D), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready),
        .host_tx_data(host_tx_data), .host_tx_chan(host_tx_chan),
        .host_rx_valid(host_rx_valid), .host_rx_ready(host_rx_ready),
        .host_rx_data(host_rx_data), .host_rx_chan(host_rx_chan),
        .irq(irq)
    );

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_word(int txc, int rxc, logic [3:0] ch);
        return {8'(txc), 8'(rxc), 8'h0, ch,
                rxc == 0, rxc == D, txc == 0, txc == D};
    endfunction

    task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Driver: transmit write plus scoreboard entry when it should be kept.
    task automatic tx_send(input int ch, input logic [31:0] d, input bit kept);
        cpu_write(8'(8'h20 + 8 * ch), d);
        if (kept) exp_tx.push_back({4'(ch), d});
    endtask

    // Driver: host offers one RX word; scoreboard records it if taken.
    task automatic rx_offer(input logic [3:0] ch, input logic [31:0] d,
                            output logic taken);
        @(posedge clk); #1;
        host_rx_valid = 1'b1; host_rx_chan = ch; host_rx_data = d;
        @(negedge clk);
        taken = host_rx_ready;
        if (taken) exp_rx.push_back({ch, d});
        @(posedge clk); #1;
        host_rx_valid = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string req);
        @(negedge clk);
        check(irq === e, req, 64'(irq), 64'(e));
    endtask

    // Monitor: compares each host TX transfer against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && host_tx_valid && host_tx_ready) begin
            if (exp_tx.size() == 0) begin
                check(1'b0, "R2 unexpected word", {28'h0, host_tx_chan, host_tx_data}, 64'h0);
            end else begin
                logic [35:0] e;
                e = exp_tx.pop_front();
                check({host_tx_chan, host_tx_data} === e, "R2/R3 tx word",
                      64'({host_tx_chan, host_tx_data}), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic tk;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 / R6 / R1: reset state
        cpu_read(8'h10, rd);
        check(rd === stat_word(0, 0, 0), "R11 status", 64'(rd), 64'(stat_word(0, 0, 0)));
        cpu_read(8'h08, rd);
        check(rd === 32'h0000_0808, "R1 config reset", 64'(rd), 64'h808);
        check_irq(1'b0, "R11 irq");
        cpu_read(8'h00, rd);
        check(rd === 32'h0, "R1 access reads zero", 64'(rd), 64'h0);

        // R1: only threshold fields are writable
        cpu_write(8'h08, 32'hFFFF_FFFF);
        cpu_read(8'h08, rd);
        check(rd === 32'h000F_0808, "R1 config readback", 64'(rd), 64'hF0808);
        cpu_write(8'h08, 32'h0);

        // R7: TX modes (host not draining)
        cpu_write(8'h08, 32'h0004_0000);
        check_irq(1'b1, "R7 tx empty");
        tx_send(5, 32'hA5A5_0001, 1);
        check_irq(1'b0, "R7 tx empty left");
        cpu_write(8'h08, 32'h000C_0000);
        tx_send(0, 32'h1234_5678, 1);
        check_irq(1'b1, "R7 near empty at 2");
        tx_send(15, 32'hDEAD_BEEF, 1);
        check_irq(1'b0, "R7 near empty at 3");
        cpu_write(8'h08, 32'h0008_0000);
        for (int i = 3; i < D - 1; i++) tx_send(i, 32'hC000_0000 + i, 1);
        check_irq(1'b1, "R7 not full at 7");
        tx_send(9, 32'h0BAD_F00D, 1);
        check_irq(1'b0, "R7 not full at 8");

        // R3: write while full is dropped
        tx_send(12, 32'hFFFF_0000, 0);
        cpu_read(8'h10, rd);
        check(rd === stat_word(D, 0, 0), "R3/R6 status full", 64'(rd), 64'(stat_word(D, 0, 0)));
        cpu_write(8'h08, 32'h0);

        // R2: drain through the host stream, monitor compares
        @(posedge clk); #1 host_tx_ready = 1'b1;
        for (int i = 0; i < 40 && exp_tx.size() != 0; i++) @(posedge clk);
        #1 host_tx_ready = 1'b0;
        cpu_read(8'h10, rd);
        check(rd === stat_word(0, 0, 0), "R2 tx drained", 64'(rd), 64'(stat_word(0, 0, 0)));

        // R4: head channel visible in status, advances after pop
        rx_offer(4'd2, 32'h1111_0002, tk);
        rx_offer(4'd9, 32'h2222_0009, tk);
        rx_offer(4'd14, 32'h3333_000E, tk);
        cpu_read(8'h10, rd);
        check(rd === stat_word(0, 3, 4'd2), "R4/R6 status head 2", 64'(rd), 64'(stat_word(0, 3, 4'd2)));
        for (int i = 0; i < 3; i++) begin
            logic [35:0] e;
            e = exp_rx.pop_front();
            cpu_read(8'h18, rd);
            check(rd === e[31:0], "R4 rx data", 64'(rd), 64'(e[31:0]));
            if (exp_rx.size() != 0) begin
                cpu_read(8'h10, rd);
                check(rd[7:4] === exp_rx[0][35:32], "R4 head chan advance",
                      64'(rd[7:4]), 64'(exp_rx[0][35:32]));
            end
        end

        // R5: empty read returns zero and leaves state alone
        cpu_read(8'h18, rd);
        check(rd === 32'h0, "R5 empty read", 64'(rd), 64'h0);
        cpu_read(8'h10, rd);
        check(rd === stat_word(0, 0, 0), "R5 no pop", 64'(rd), 64'(stat_word(0, 0, 0)));

        // R8: RX modes
        cpu_write(8'h08, 32'h0002_0000);
        check_irq(1'b0, "R8 not empty idle");
        rx_offer(4'd1, 32'h4000_0000, tk);
        check_irq(1'b1, "R8 not empty");
        cpu_write(8'h08, 32'h0003_0000);
        check_irq(1'b0, "R8 near full at 1");
        for (int i = 1; i < 5; i++) rx_offer(4'(i + 3), 32'h4000_0000 + i, tk);
        check_irq(1'b0, "R8 near full at 5");
        rx_offer(4'd7, 32'h4000_0005, tk);
        check_irq(1'b1, "R8 near full at 6");
        cpu_write(8'h08, 32'h0001_0000);
        rx_offer(4'd8, 32'h4000_0006, tk);
        check_irq(1'b0, "R8 full at 7");
        rx_offer(4'd10, 32'h4000_0007, tk);
        check_irq(1'b1, "R8 full at 8");

        // R10: full refuses the host
        rx_offer(4'd11, 32'hEEEE_EEEE, tk);
        check(tk === 1'b0, "R10 ready low at full", 64'(tk), 64'h0);
        cpu_read(8'h10, rd);
        check(rd === stat_word(0, D, exp_rx[0][35:32]), "R10 count held",
              64'(rd), 64'(stat_word(0, D, exp_rx[0][35:32])));

        // R9: OR of both sides, level follows configuration
        cpu_write(8'h08, 32'h0004_0000);
        check_irq(1'b1, "R9 tx side alone");
        cpu_write(8'h08, 32'h0000_0000);
        check_irq(1'b0, "R9 both off");

        // R4: drain RX in order
        while (exp_rx.size() != 0) begin
            logic [35:0] e;
            e = exp_rx.pop_front();
            cpu_read(8'h18, rd);
            check(rd === e[31:0], "R4 rx drain", 64'(rd), 64'(e[31:0]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule